// File: doc/BRIEF.md
# SPI Passive Bus Monitor

This block listens to an SPI bus without driving any of its wires. It samples the serial clock, both data lines and the chip select with a fast system clock. From these samples it rebuilds full-duplex data words. Each finished word is offered downstream as one event. The event holds the word sent by the controller, the word sent back by the peripheral, a flag for each data line, the length of the word in system clocks and a warning flag. The length in clocks is enough to work out the bitrate downstream.

A second, single-cycle event stream reports the chip select. One event appears once the block comes out of reset. After that, one event appears for every change of level, and each carries the old level and the new level. The clock polarity, the clock phase, the bit order, the chip-select polarity and whether a chip select is wired at all are set by static configuration inputs. The word length is a parameter.

Top module: `spi_bus_monitor`

## Requirements
- R1: A bit is captured on the rising synchronized SCLK edge when cfg_cpol equals cfg_cpha (modes 0 and 3), and on the falling edge when they differ (modes 1 and 2).
- R2: With cfg_lsb_first=0 the k-th captured bit of a word (k from 0) lands at bit W-1-k of the reported word. With cfg_lsb_first=1 it lands at bit k.
- R3: A word event is raised when the W-th bit is captured, and the bit counter then restarts. word_cycles equals the number of system clocks from the capture of the first bit to the capture of the last bit, both included. With bits spaced P clocks apart this is (W-1)*P+1.
- R4: Once the input synchronizers hold valid data after reset, exactly one cs event is emitted with cs_evt_old_known=0. When cfg_cs_used=1 it has cs_evt_new_known=1 and cs_evt_new equal to the chip-select level. Otherwise cs_evt_new_known=0 and cs_evt_new=0.
- R5: While cfg_cs_used=1, every change of the synchronized chip select emits a one-cycle cs event with both known flags at 1, cs_evt_old holding the previous level and cs_evt_new holding the new level. Any partly assembled word is discarded.
- R6: word_cs_warn is 1 exactly when the chip select was inactive as the word's first bit was captured. Active means high when cfg_cs_active_high=1 and low otherwise. word_cs_warn is always 0 when cfg_cs_used=0.
- R7: When en_mosi (or en_miso) is 0 at word completion, that line's ok flag is 0 and its reported word is all zeros. When it is 1, the ok flag is 1.
- R8: While word_valid=1 and word_ready=0, the word outputs hold their values. A word that completes during that time is dropped and sets overflow. overflow stays set until reset.
- R9: During and right after reset, word_valid, cs_evt_valid and overflow are 0.
- R10: With cfg_cs_used=0, no cs event other than the startup one is emitted, whatever the chip-select pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: on trailing edge |
| cfg_lsb_first | input | 1 | 1: first bit is the word's LSB |
| cfg_cs_active_high | input | 1 | 1: chip select active high |
| cfg_cs_used | input | 1 | 1: chip-select pin is wired |
| en_mosi | input | 1 | Controller-to-peripheral line monitored |
| en_miso | input | 1 | Peripheral-to-controller line monitored |
| spi_sclk | input | 1 | Bus serial clock |
| spi_mosi | input | 1 | Controller-to-peripheral data |
| spi_miso | input | 1 | Peripheral-to-controller data |
| spi_cs | input | 1 | Bus chip select |
| word_valid | output | 1 | Word event pending |
| word_ready | input | 1 | Downstream accepts word event |
| word_mosi | output | W | Controller-to-peripheral word |
| word_miso | output | W | Peripheral-to-controller word |
| word_mosi_ok | output | 1 | word_mosi is meaningful |
| word_miso_ok | output | 1 | word_miso is meaningful |
| word_cycles | output | CYC_W | First-to-last bit span in system clocks |
| word_cs_warn | output | 1 | Word began while chip select inactive |
| overflow | output | 1 | Sticky: a word was dropped |
| cs_evt_valid | output | 1 | One-cycle chip-select event |
| cs_evt_old | output | 1 | Previous chip-select level |
| cs_evt_old_known | output | 1 | cs_evt_old is meaningful |
| cs_evt_new | output | 1 | New chip-select level |
| cs_evt_new_known | output | 1 | cs_evt_new is meaningful |

## Verification
A wrong bit counter or a wrong shift position shows up as a wrong or shifted word at the next word event, which is at most W bus clocks away. A wrong capture-edge choice shows the same way within that word. A stale chip-select register shows within three system clocks, either as a missing cs event or as a spurious one. A counter that survives a chip-select change shows as a word made of bits from two transfers. A faulty holding register shows as data changing while word_valid waits for ready, or as overflow missing after the second unaccepted word.

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor #(
  parameter int W     = 8,
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb_first,
  input  logic             cfg_cs_active_high,
  input  logic             cfg_cs_used,
  input  logic             en_mosi,
  input  logic             en_miso,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  input  logic             spi_miso,
  input  logic             spi_cs,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [W-1:0]     word_mosi,
  output logic [W-1:0]     word_miso,
  output logic             word_mosi_ok,
  output logic             word_miso_ok,
  output logic [CYC_W-1:0] word_cycles,
  output logic             word_cs_warn,
  output logic             overflow,
  output logic             cs_evt_valid,
  output logic             cs_evt_old,
  output logic             cs_evt_old_known,
  output logic             cs_evt_new,
  output logic             cs_evt_new_known
);
  localparam int CNT_W = $clog2(W + 1);

  logic [1:0] sy_sclk, sy_mosi, sy_miso, sy_cs;
  logic [1:0] arm;
  logic live, sclk_q, cs_q, warn_q;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0] acc_mo, acc_mi;
  logic [CYC_W-1:0] dur;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy_sclk <= '0; sy_mosi <= '0; sy_miso <= '0; sy_cs <= '0;
    end else begin
      sy_sclk <= {sy_sclk[0], spi_sclk};
      sy_mosi <= {sy_mosi[0], spi_mosi};
      sy_miso <= {sy_miso[0], spi_miso};
      sy_cs   <= {sy_cs[0], spi_cs};
    end

  wire sclk_s = sy_sclk[1];
  wire cs_s   = sy_cs[1];
  wire rise   = sclk_s & ~sclk_q;
  wire fall   = ~sclk_s & sclk_q;
  wire cap    = live & ((cfg_cpol ^ cfg_cpha) ? fall : rise);
  wire cs_chg = live & cfg_cs_used & (cs_s != cs_q);
  wire cs_on  = cfg_cs_active_high ? cs_s : ~cs_s;
  wire first  = cs_chg | (cnt == '0);

  logic [CNT_W-1:0] idx, pos;
  logic [W-1:0] mask, nxt_mo, nxt_mi;
  logic [CYC_W-1:0] dur_inc;
  logic last, warn_now;

  always_comb begin
    idx      = first ? '0 : cnt;
    pos      = cfg_lsb_first ? idx : CNT_W'(W - 1) - idx;
    mask     = {{(W-1){1'b0}}, 1'b1} << pos;
    nxt_mo   = (first ? '0 : acc_mo) | (sy_mosi[1] ? mask : '0);
    nxt_mi   = (first ? '0 : acc_mi) | (sy_miso[1] ? mask : '0);
    last     = cap & (idx == CNT_W'(W - 1));
    dur_inc  = (&dur) ? dur : dur + 1'b1;
    warn_now = first ? (cfg_cs_used & ~cs_on) : warn_q;
  end

  // bit assembly
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; acc_mo <= '0; acc_mi <= '0; dur <= '0; warn_q <= 1'b0;
    end else begin
      dur <= (cap & first) ? CYC_W'(1) : dur_inc;
      if (cap) begin
        cnt    <= last ? '0 : idx + 1'b1;
        acc_mo <= nxt_mo;
        acc_mi <= nxt_mi;
        warn_q <= warn_now;
      end else if (cs_chg) begin
        cnt <= '0;
      end
    end

  // startup and chip-select events
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm <= '0; live <= 1'b0; sclk_q <= 1'b0; cs_q <= 1'b0;
      cs_evt_valid <= 1'b0; cs_evt_old <= 1'b0; cs_evt_old_known <= 1'b0;
      cs_evt_new <= 1'b0; cs_evt_new_known <= 1'b0;
    end else if (!live) begin
      arm <= arm + 1'b1;
      cs_evt_valid <= 1'b0;
      if (arm == 2'd2) begin
        live             <= 1'b1;
        sclk_q           <= sclk_s;
        cs_q             <= cs_s;
        cs_evt_valid     <= 1'b1;
        cs_evt_old       <= 1'b0;
        cs_evt_old_known <= 1'b0;
        cs_evt_new       <= cfg_cs_used & cs_s;
        cs_evt_new_known <= cfg_cs_used;
      end
    end else begin
      sclk_q       <= sclk_s;
      cs_q         <= cs_s;
      cs_evt_valid <= cs_chg;
      if (cs_chg) begin
        cs_evt_old       <= cs_q;
        cs_evt_new       <= cs_s;
        cs_evt_old_known <= 1'b1;
        cs_evt_new_known <= 1'b1;
      end
    end

  // one-entry word holding register
  wire hold = word_valid & ~word_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_valid <= 1'b0; word_mosi <= '0; word_miso <= '0;
      word_mosi_ok <= 1'b0; word_miso_ok <= 1'b0;
      word_cycles <= '0; word_cs_warn <= 1'b0; overflow <= 1'b0;
    end else if (last & hold) begin
      overflow <= 1'b1;
    end else if (last) begin
      word_valid   <= 1'b1;
      word_mosi    <= en_mosi ? nxt_mo : '0;
      word_miso    <= en_miso ? nxt_mi : '0;
      word_mosi_ok <= en_mosi;
      word_miso_ok <= en_miso;
      word_cycles  <= first ? CYC_W'(1) : dur_inc;
      word_cs_warn <= warn_now;
    end else if (word_ready) begin
      word_valid <= 1'b0;
    end
endmodule

// File: rtl/spi_bus_monitor_checks.sv
module spi_bus_monitor_checks #(
  parameter int W     = 8,
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_cs_used,
  input logic             word_valid,
  input logic             word_ready,
  input logic [W-1:0]     word_mosi,
  input logic [W-1:0]     word_miso,
  input logic             word_mosi_ok,
  input logic             word_miso_ok,
  input logic [CYC_W-1:0] word_cycles,
  input logic             overflow,
  input logic             cs_evt_valid,
  input logic             cs_evt_old,
  input logic             cs_evt_old_known,
  input logic             cs_evt_new,
  input logic             cs_evt_new_known
);
  logic seen_start;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_start <= 1'b0;
    else if (cs_evt_valid && !cs_evt_old_known) seen_start <= 1'b1;

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_mosi) && $stable(word_miso) && $stable(word_cycles));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r5_change_levels: assert property (@(posedge clk) disable iff (!rst_n)
    cs_evt_valid && cs_evt_old_known |-> cs_evt_new_known && (cs_evt_old != cs_evt_new));

  a_r7_mosi_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_mosi_ok |-> word_mosi == '0);

  a_r7_miso_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_miso_ok |-> word_miso == '0);

  a_r3_cycles_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_cycles != '0);

  a_r4_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    seen_start |-> !(cs_evt_valid && !cs_evt_old_known));

  a_r10_no_change_unused: assert property (@(posedge clk) disable iff (!rst_n)
    cs_evt_valid && !cfg_cs_used |-> !cs_evt_old_known && !cs_evt_new_known);
endmodule

bind spi_bus_monitor spi_bus_monitor_checks #(.W(W), .CYC_W(CYC_W)) chk (
  .clk(clk), .rst_n(rst_n), .cfg_cs_used(cfg_cs_used),
  .word_valid(word_valid), .word_ready(word_ready),
  .word_mosi(word_mosi), .word_miso(word_miso),
  .word_mosi_ok(word_mosi_ok), .word_miso_ok(word_miso_ok),
  .word_cycles(word_cycles), .overflow(overflow),
  .cs_evt_valid(cs_evt_valid), .cs_evt_old(cs_evt_old),
  .cs_evt_old_known(cs_evt_old_known), .cs_evt_new(cs_evt_new),
  .cs_evt_new_known(cs_evt_new_known)
);

// File: tb/spi_bus_monitor_test.sv
module spi_bus_monitor_test;
  localparam int W = 8;
  localparam int CYC_W = 16;
  localparam int H = 4;
  localparam int SPAN = (W - 1) * 2 * H + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cpol = 0, cpha = 0, lsb = 0, acth = 0, used = 1;
  logic en_mo = 1, en_mi = 1, sclk = 0, mosi = 0, miso = 0, cs = 1, ready = 1;
  logic word_valid, word_mosi_ok, word_miso_ok, word_cs_warn, overflow;
  logic [W-1:0] word_mosi, word_miso;
  logic [CYC_W-1:0] word_cycles;
  logic cs_evt_valid, cs_evt_old, cs_evt_old_known, cs_evt_new, cs_evt_new_known;

  spi_bus_monitor #(.W(W), .CYC_W(CYC_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_lsb_first(lsb), .cfg_cs_active_high(acth), .cfg_cs_used(used),
    .en_mosi(en_mo), .en_miso(en_mi), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs(cs), .word_valid(word_valid), .word_ready(ready),
    .word_mosi(word_mosi), .word_miso(word_miso), .word_mosi_ok(word_mosi_ok),
    .word_miso_ok(word_miso_ok), .word_cycles(word_cycles),
    .word_cs_warn(word_cs_warn), .overflow(overflow),
    .cs_evt_valid(cs_evt_valid), .cs_evt_old(cs_evt_old),
    .cs_evt_old_known(cs_evt_old_known), .cs_evt_new(cs_evt_new),
    .cs_evt_new_known(cs_evt_new_known));

  int nchk = 0, nerr = 0;
  int nwords = 0, nevt = 0;
  logic [W-1:0] g_mo, g_mi;
  logic [CYC_W-1:0] g_cyc;
  logic g_mok, g_mik, g_warn, e_old, e_oldk, e_new, e_newk;

  always @(negedge clk)
    if (rst_n) begin
      if (word_valid && ready) begin
        nwords++; g_mo = word_mosi; g_mi = word_miso; g_cyc = word_cycles;
        g_mok = word_mosi_ok; g_mik = word_miso_ok; g_warn = word_cs_warn;
      end
      if (cs_evt_valid) begin
        nevt++; e_old = cs_evt_old; e_oldk = cs_evt_old_known;
        e_new = cs_evt_new; e_newk = cs_evt_new_known;
      end
    end

  task automatic chk(input string rq, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic cs_level(input logic active);
    return active ? acth : ~acth;
  endfunction

  task automatic start(input logic p, input logic h, input logic l, input logic a, input logic u);
    int ev0;
    rst_n = 1'b0; cpol = p; cpha = h; lsb = l; acth = a; used = u;
    en_mo = 1; en_mi = 1; ready = 1; sclk = p; mosi = 0; miso = 0; cs = cs_level(0);
    ticks(3);
    ev0 = nevt;
    rst_n = 1'b1;
    chk("R9 valid", word_valid, 0);
    chk("R9 cs_evt", cs_evt_valid, 0);
    chk("R9 overflow", overflow, 0);
    ticks(6);
    chk("R4 count", nevt - ev0, 1);
    chk("R4 old_known", e_oldk, 0);
    chk("R4 new_known", e_newk, u);
    chk("R4 new", e_new, u ? cs_level(0) : 1'b0);
  endtask

  task automatic xfer(input logic [W-1:0] mo, input logic [W-1:0] mi, input int nb);
    for (int k = 0; k < nb; k++) begin
      if (!cpha) begin
        mosi = lsb ? mo[k] : mo[W-1-k]; miso = lsb ? mi[k] : mi[W-1-k];
        ticks(H); sclk = ~sclk; ticks(H); sclk = ~sclk;
      end else begin
        sclk = ~sclk;
        mosi = lsb ? mo[k] : mo[W-1-k]; miso = lsb ? mi[k] : mi[W-1-k];
        ticks(H); sclk = ~sclk; ticks(H);
      end
    end
    ticks(6);
  endtask

  task automatic set_cs(input logic active, input logic expect_evt);
    int ev0;
    ev0 = nevt;
    cs = cs_level(active);
    ticks(5);
    if (expect_evt) begin
      chk("R5 count", nevt - ev0, 1);
      chk("R5 old", {e_oldk, e_old}, {1'b1, cs_level(!active)});
      chk("R5 new", {e_newk, e_new}, {1'b1, cs_level(active)});
    end else begin
      chk("R10 no event", nevt - ev0, 0);
    end
  endtask

  task automatic word_check(input string rq, input logic [W-1:0] mo, input logic [W-1:0] mi,
                            input int w0, input logic warn);
    chk({rq, " count"}, nwords - w0, 1);
    chk({rq, " mosi"}, g_mo, mo);
    chk({rq, " miso"}, g_mi, mi);
    chk({rq, " cycles R3"}, g_cyc, SPAN);
    chk({rq, " warn R6"}, g_warn, warn);
  endtask

  initial begin
    int w0, ev0;
    logic [W-1:0] mo, mi;
    for (int c = 0; c < 16; c++) begin
      start(c[0], c[1], c[2], c[3], 1'b1);
      mo = W'(c * 29 + 7); mi = W'(c * 53 + 200);
      set_cs(1, 1);
      w0 = nwords;
      xfer(mo, mi, W);
      word_check("R1 R2", mo, mi, w0, 0);
      chk("R7 ok flags", {g_mok, g_mik}, 2'b11);
      set_cs(0, 1);
      w0 = nwords;
      xfer(~mo, mi ^ 8'h5A, W);
      word_check("R6 inactive", ~mo, mi ^ 8'h5A, w0, 1);
    end

    // R5: partial word discarded on chip-select change
    start(0, 0, 0, 0, 1);
    set_cs(1, 1);
    w0 = nwords;
    xfer(8'hFF, 8'hFF, 3);
    set_cs(0, 1);
    set_cs(1, 1);
    xfer(8'h12, 8'h34, W);
    word_check("R5 discard", 8'h12, 8'h34, w0, 0);

    // R7: disabled lines
    en_mi = 0; w0 = nwords;
    xfer(8'hC3, 8'h81, W);
    chk("R7 miso off data", g_mi, 0);
    chk("R7 miso off flags", {g_mok, g_mik}, 2'b10);
    chk("R7 mosi data", g_mo, 8'hC3);
    en_mi = 1; en_mo = 0; w0 = nwords;
    xfer(8'hC3, 8'h81, W);
    chk("R7 mosi off data", g_mo, 0);
    chk("R7 mosi off flags", {g_mok, g_mik}, 2'b01);
    chk("R7 miso data", g_mi, 8'h81);
    en_mo = 1;

    // R8: holding register and overflow
    ready = 0; w0 = nwords;
    xfer(8'hA1, 8'hB2, W);
    chk("R8 held valid", word_valid, 1);
    chk("R8 held data", word_mosi, 8'hA1);
    chk("R8 no overflow yet", overflow, 0);
    xfer(8'h0F, 8'hF0, W);
    chk("R8 overflow", overflow, 1);
    chk("R8 first kept mosi", word_mosi, 8'hA1);
    chk("R8 first kept miso", word_miso, 8'hB2);
    ready = 1; ticks(2);
    chk("R8 accepted once", nwords - w0, 1);
    chk("R8 drained", word_valid, 0);
    chk("R8 sticky", overflow, 1);

    // R10: chip select unused
    start(1, 1, 1, 0, 0);
    ev0 = nevt;
    set_cs(1, 0);
    set_cs(0, 0);
    w0 = nwords;
    xfer(8'h96, 8'h69, W);
    word_check("R10 unused", 8'h96, 8'h69, w0, 0);
    chk("R10 total events", nevt - ev0, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule